// File: doc/BRIEF.md
# I2C Target Port with Sticky Status

This block is the target (slave) side of a two-wire I2C bus, as a microcontroller peripheral would carry it. It watches SCL and SDA and pulls SDA low through a single output-enable pin, so the open-drain wiring stays outside the block. A controller on the bus opens a transfer with a START condition, sends a 7-bit address MSB first and then a read/write bit. After that come data bytes and finally a STOP condition. When the address equals the programmed own address, the port acknowledges. It then either shifts bytes out from a transmit register (read) or collects bytes into a receive register (write).

The host CPU sees sticky status outputs: an address-hit flag, the direction of the current transfer, the acknowledge level last returned by the controller, and a bus time-out flag. One interrupt request covers three events: an address match, the end of each data byte, and a time-out. The flags let software tell these causes apart. The request stays up until software pulses the clear input. A separate wake-up request fires on an address match while the device reports that it is asleep and the wake enable is set.

Top module: `i2c_target_port`

## Requirements
- R1: After reset, sda_oe, irq, addr_hit, tmo_flag, rx_nack, dir_rd and wake_req are all 0.
- R2: When the 7 address bits after a START equal own_addr, addr_hit and irq go to 1 and SDA is pulled low during the 9th clock (acknowledge).
- R3: When the address does not match, SDA is not pulled low on the 9th clock, no flag changes, and later bytes up to the next START are not acknowledged.
- R4: dir_rd takes the 8th bit of the address byte: 1 selects transmit (controller reads), 0 selects receive (controller writes).
- R5: In receive mode each 8-bit byte, MSB first, appears on rx_byte, irq goes to 1, and the byte is acknowledged by pulling SDA low on the 9th clock.
- R6: In transmit mode tx_byte is sent MSB first (a 1 bit releases SDA). After each acknowledged byte the next byte is taken from tx_byte as it stands at the end of the 9th clock.
- R7: On the 9th clock of a transmitted byte the SDA level is stored in rx_nack (0 = acknowledged, 1 = not) and irq goes to 1. After a 1 the port releases SDA and drives no further bits until a new START.
- R8: If SCL stays low for more than tmo_limit system clocks during a transfer, tmo_flag and irq go to 1, SDA is released and the port ignores the bus until the next START.
- R9: While en is 0 the port ignores the bus: it never pulls SDA low and sets no flag.
- R10: An address match while sleeping and wake_en are both 1 sets wake_req. wake_req returns to 0 one clock after wake_en is 0.
- R11: irq, addr_hit and tmo_flag stay at 1 until a clock with irq_clr at 1, which returns them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Port enable |
| own_addr | input | 7 | Own 7-bit bus address |
| tmo_limit | input | TMO_W | Longest allowed SCL low time, in system clocks |
| tx_byte | input | 8 | Next byte to transmit |
| irq_clr | input | 1 | Pulse: clears irq, addr_hit, tmo_flag |
| sleeping | input | 1 | Device is in a low-power state |
| wake_en | input | 1 | Address-match wake-up enable |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_byte | output | 8 | Last received byte |
| addr_hit | output | 1 | Sticky address-match flag |
| dir_rd | output | 1 | Direction of current transfer (1 = read) |
| rx_nack | output | 1 | Acknowledge level returned by the controller |
| tmo_flag | output | 1 | Sticky bus time-out flag |
| irq | output | 1 | Sticky interrupt request |
| wake_req | output | 1 | Wake-up request |

## Verification
A wrong bit counter or state shows on the bus within one byte. The acknowledge would land on the 8th or 10th clock, and either the controller model reads a missing ACK or a transmitted byte comes back shifted, on the very transfer that hits it. A wrong sticky-flag update shows as irq or addr_hit dropping on its own during the long idle gaps the bench leaves before clearing. A broken time-out counter shows as tmo_flag staying 0, or as the port still acknowledging bytes after the SCL stall.

// File: rtl/i2c_tp_pkg.sv
package i2c_tp_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;
   localparam int CNT_W  = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RX,
      ST_RACK,
      ST_TX,
      ST_TACK
   } tp_state_e;
endpackage

// File: rtl/i2c_tp_sync.sv
module i2c_tp_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '1;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_tp_timeout.sv
module i2c_tp_timeout #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   logic [TMO_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (!run || restart) cnt <= '0;
      else if (cnt != '1) cnt <= cnt + 1'b1;
   end

   assign expired = run && !restart && (cnt >= limit);
endmodule

// File: rtl/i2c_target_port.sv
module i2c_target_port
   import i2c_tp_pkg::*;
#(
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [ADDR_W-1:0]   own_addr,
   input  logic [TMO_W-1:0]    tmo_limit,
   input  logic [BYTE_W-1:0]   tx_byte,
   input  logic                irq_clr,
   input  logic                sleeping,
   input  logic                wake_en,
   input  logic                scl_i,
   input  logic                sda_i,
   output logic                sda_oe,
   output logic [BYTE_W-1:0]   rx_byte,
   output logic                addr_hit,
   output logic                dir_rd,
   output logic                rx_nack,
   output logic                tmo_flag,
   output logic                irq,
   output logic                wake_req
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TMO_W < 4) begin : g_bad_tmo
      $error("TMO_W must be at least 4");
   end

   logic [1:0]        line_s;
   logic              scl_s, sda_s, scl_d, sda_d;
   logic              scl_rise, scl_fall, start_c, stop_c;
   logic              tmo_exp, tmo_run;
   tp_state_e         state;
   logic [BYTE_W-1:0] shreg;
   logic [CNT_W-1:0]  bitcnt;

   i2c_tp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
   );
   assign scl_s = line_s[1];
   assign sda_s = line_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
   assign tmo_run  = en && (state != ST_IDLE) && !scl_s;

   i2c_tp_timeout #(.TMO_W(TMO_W)) u_tmo (
      .clk(clk), .rst_n(rst_n), .run(tmo_run),
      .restart(scl_rise | scl_fall), .limit(tmo_limit), .expired(tmo_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         bitcnt   <= '0;
         sda_oe   <= 1'b0;
         rx_byte  <= '0;
         addr_hit <= 1'b0;
         dir_rd   <= 1'b0;
         rx_nack  <= 1'b0;
         tmo_flag <= 1'b0;
         irq      <= 1'b0;
         wake_req <= 1'b0;
      end else begin
         if (irq_clr) begin
            irq      <= 1'b0;
            addr_hit <= 1'b0;
            tmo_flag <= 1'b0;
         end
         if (!wake_en) wake_req <= 1'b0;

         if (!en) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (tmo_exp) begin
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
            tmo_flag <= 1'b1;
            irq      <= 1'b1;
         end else if (start_c) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_c) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == LAST_BIT) begin
                     bitcnt <= '0;
                     if (shreg[BYTE_W-1:1] == own_addr) begin
                        addr_hit <= 1'b1;
                        irq      <= 1'b1;
                        dir_rd   <= shreg[0];
                        sda_oe   <= 1'b1;
                        state    <= ST_AACK;
                        if (wake_en && sleeping) wake_req <= 1'b1;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_rise) bitcnt <= 1;
                  else if (scl_fall && bitcnt == 1) begin
                     bitcnt <= '0;
                     if (dir_rd) begin
                        shreg  <= tx_byte;
                        sda_oe <= ~tx_byte[BYTE_W-1];
                        state  <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_RX;
                     end
                  end
               end
               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == LAST_BIT) begin
                     rx_byte <= shreg;
                     irq     <= 1'b1;
                     sda_oe  <= 1'b1;
                     bitcnt  <= '0;
                     state   <= ST_RACK;
                  end
               end
               ST_RACK: begin
                  if (scl_rise) bitcnt <= 1;
                  else if (scl_fall && bitcnt == 1) begin
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                     state  <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (scl_rise) bitcnt <= bitcnt + 1'b1;
                  else if (scl_fall) begin
                     if (bitcnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_TACK;
                     end else begin
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~shreg[BYTE_W-2];
                     end
                  end
               end
               ST_TACK: begin
                  if (scl_rise) begin
                     rx_nack <= sda_s;
                     irq     <= 1'b1;
                     bitcnt  <= 1;
                  end else if (scl_fall && bitcnt == 1) begin
                     bitcnt <= '0;
                     if (!rx_nack) begin
                        shreg  <= tx_byte;
                        sda_oe <= ~tx_byte[BYTE_W-1];
                        state  <= ST_TX;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_tp_chk.sv
module i2c_tp_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic irq_clr,
   input logic sleeping,
   input logic wake_en,
   input logic sda_oe,
   input logic addr_hit,
   input logic tmo_flag,
   input logic irq,
   input logic wake_req
);
   AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !sda_oe); // R9
   AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !irq_clr |=> irq); // R11
   AST_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      addr_hit && !irq_clr |=> addr_hit); // R11
   AST_TMO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_flag && !irq_clr |=> tmo_flag); // R11
   AST_HIT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_hit) |-> irq); // R2
   AST_TMO_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> irq && !sda_oe); // R8
   AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_req) |-> addr_hit && $past(sleeping) && $past(wake_en)); // R10
   AST_WAKE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_en |=> !wake_req); // R10
endmodule

bind i2c_target_port i2c_tp_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .irq_clr(irq_clr), .sleeping(sleeping),
   .wake_en(wake_en), .sda_oe(sda_oe), .addr_hit(addr_hit), .tmo_flag(tmo_flag),
   .irq(irq), .wake_req(wake_req)
);

// File: tb/tb_i2c_target_port.sv
`timescale 1ns/1ps
module tb_i2c_target_port;
   localparam int TMO_W = 16;
   localparam int Q     = 40;
   localparam logic [6:0] MY_ADDR = 7'h3A;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [6:0]       own_addr = MY_ADDR;
   logic [TMO_W-1:0] tmo_limit = 16'd100;
   logic [7:0]       tx_byte = 8'h00;
   logic             irq_clr = 1'b0;
   logic             sleeping = 1'b0;
   logic             wake_en = 1'b0;
   logic             m_scl = 1'b1;
   logic             m_low = 1'b0;
   logic             sda_line;
   logic             sda_oe, addr_hit, dir_rd, rx_nack, tmo_flag, irq, wake_req;
   logic [7:0]       rx_byte;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] exp_q[$];
   logic [7:0] mon_byte;
   event       rd_ev;

   always #2.5 clk = ~clk;
   assign sda_line = ~(m_low | sda_oe);

   i2c_target_port #(.TMO_W(TMO_W), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .own_addr(own_addr),
      .tmo_limit(tmo_limit), .tx_byte(tx_byte), .irq_clr(irq_clr),
      .sleeping(sleeping), .wake_en(wake_en), .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .rx_byte(rx_byte), .addr_hit(addr_hit), .dir_rd(dir_rd),
      .rx_nack(rx_nack), .tmo_flag(tmo_flag), .irq(irq), .wake_req(wake_req)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_bit(input logic b, output logic r);
      m_low = ~b;
      wait_q();
      m_scl = 1'b1;
      wait_q();
      r = sda_line;
      wait_q();
      m_scl = 1'b0;
      wait_q();
   endtask

   task automatic bus_start();
      m_low = 1'b0;
      m_scl = 1'b1;
      wait_q();
      m_low = 1'b1;
      wait_q();
      m_scl = 1'b0;
      wait_q();
   endtask

   task automatic bus_stop();
      m_low = 1'b1;
      wait_q();
      m_scl = 1'b1;
      wait_q();
      m_low = 1'b0;
      wait_q();
   endtask

   task automatic put_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
      bus_bit(1'b1, ack);
   endtask

   task automatic get_bits(output logic [7:0] v);
      logic r;
      v = '0;
      for (int i = 0; i < 8; i++) begin
         bus_bit(1'b1, r);
         v = {v[6:0], r};
      end
   endtask

   task automatic get_byte_sb(output logic [7:0] v);
      get_bits(v);
      mon_byte = v;
      ->rd_ev;
   endtask

   task automatic ack_bit(input logic nack);
      logic r;
      bus_bit(nack, r);
   endtask

   task automatic drive_tx(input logic [7:0] v);
      tx_byte = v;
      exp_q.push_back(v);
   endtask

   task automatic pulse_clr();
      @(negedge clk) irq_clr = 1'b1;
      @(negedge clk) irq_clr = 1'b0;
      @(negedge clk);
   endtask

   initial begin : monitor
      forever begin
         @(rd_ev);
         if (exp_q.size() == 0) chk(1'b0, "R6 unexpected byte", mon_byte, 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(mon_byte == e, "R6 transmitted byte", mon_byte, e);
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic       ack;
      logic [7:0] v;
      repeat (5) @(negedge clk);
      chk(!sda_oe && !irq && !addr_hit && !tmo_flag && !rx_nack && !dir_rd && !wake_req,
          "R1 reset state", {sda_oe, irq, addr_hit, tmo_flag, rx_nack, dir_rd, wake_req}, 0);
      rst_n = 1'b1;
      en = 1'b1;
      repeat (5) @(negedge clk);

      // write transfer: R2, R4, R5
      bus_start();
      put_byte({MY_ADDR, 1'b0}, ack);
      chk(ack == 1'b0, "R2 address ack", ack, 0);
      chk(addr_hit && irq, "R2 hit flag and irq", {addr_hit, irq}, 2'b11);
      chk(dir_rd == 1'b0, "R4 write direction", dir_rd, 0);
      pulse_clr();
      put_byte(8'hA5, ack);
      chk(ack == 1'b0, "R5 data ack", ack, 0);
      chk(rx_byte == 8'hA5, "R5 received byte", rx_byte, 8'hA5);
      chk(irq == 1'b1 && addr_hit == 1'b0, "R5 byte irq", {irq, addr_hit}, 2'b10);
      pulse_clr();
      put_byte(8'h3C, ack);
      chk(rx_byte == 8'h3C && ack == 1'b0, "R5 second byte", rx_byte, 8'h3C);
      bus_stop();
      pulse_clr();

      // mismatch: R3
      bus_start();
      put_byte({7'h11, 1'b0}, ack);
      chk(ack == 1'b1, "R3 no ack on foreign address", ack, 1);
      chk(!addr_hit && !irq, "R3 no flags", {addr_hit, irq}, 0);
      put_byte(8'h00, ack);
      chk(ack == 1'b1 && !irq, "R3 later byte ignored", {ack, irq}, 2'b10);
      bus_stop();

      // read transfer: R4, R6, R7
      drive_tx(8'hC3);
      bus_start();
      put_byte({MY_ADDR, 1'b1}, ack);
      chk(ack == 1'b0 && dir_rd == 1'b1, "R4 read direction", {ack, dir_rd}, 2'b01);
      pulse_clr();
      get_byte_sb(v);
      drive_tx(8'h5E);
      ack_bit(1'b0);
      chk(rx_nack == 1'b0 && irq == 1'b1, "R7 ack stored", {rx_nack, irq}, 2'b01);
      pulse_clr();
      get_byte_sb(v);
      ack_bit(1'b1);
      chk(rx_nack == 1'b1 && irq == 1'b1, "R7 nack stored", {rx_nack, irq}, 2'b11);
      get_bits(v);
      chk(v == 8'hFF, "R7 SDA released after nack", v, 8'hFF);
      bus_stop();
      chk(exp_q.size() == 0, "R6 all bytes seen", exp_q.size(), 0);
      pulse_clr();

      // time-out: R8
      bus_start();
      put_byte({MY_ADDR, 1'b0}, ack);
      pulse_clr();
      repeat (300) @(negedge clk);
      chk(tmo_flag && irq && !sda_oe, "R8 time-out flag", {tmo_flag, irq, sda_oe}, 3'b110);
      put_byte(8'h55, ack);
      chk(ack == 1'b1, "R8 idle after time-out", ack, 1);
      bus_stop();
      pulse_clr();

      // disabled: R9
      en = 1'b0;
      bus_start();
      put_byte({MY_ADDR, 1'b0}, ack);
      chk(ack == 1'b1 && !addr_hit && !irq, "R9 disabled ignores bus",
          {ack, addr_hit, irq}, 3'b100);
      bus_stop();
      en = 1'b1;
      repeat (5) @(negedge clk);

      // wake-up: R10, sticky: R11
      sleeping = 1'b1;
      wake_en = 1'b1;
      bus_start();
      put_byte({MY_ADDR, 1'b0}, ack);
      chk(wake_req == 1'b1, "R10 wake request", wake_req, 1);
      bus_stop();
      sleeping = 1'b0;
      repeat (500) @(negedge clk);
      chk(irq && addr_hit, "R11 flags sticky", {irq, addr_hit}, 2'b11);
      wake_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(wake_req == 1'b0, "R10 wake cleared", wake_req, 0);
      pulse_clr();
      chk(!irq && !addr_hit && !tmo_flag, "R11 cleared", {irq, addr_hit, tmo_flag}, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule